// File: doc/BRIEF.md
# Four-Phase Handshake Clock-Domain Bridge

This block carries one data word at a time from a sending clock domain to a receiving clock domain. On the sending side a client offers a word with a valid/ready push. The bridge stores the word in a holding register and raises a request line toward the receiver. The receiving side passes that request through its own synchronizer chain. On the rising edge of the synchronized copy it captures the word and presents it for one cycle with a valid strobe. In the same cycle it raises an acknowledge line.

The acknowledge returns to the sending side through a second synchronizer chain. The sender then drops its request, and the receiver drops its acknowledge in turn. Only after that acknowledge has gone low again on the sending side does the bridge take another word. Each transfer therefore passes through all four transitions. Neither side makes any assumption about the other side's clock rate or wire delay. Each crossing control line is synchronized at exactly one point. The data bus itself is not synchronized: it is held still for the whole time the receiver may sample it.

Top module: `hs_bridge`

## Requirements
- R1: While either reset is low, `r_valid` is 0. Once both resets have been released for a few cycles with no traffic, `s_ready` reads 1 and `r_valid` reads 0.
- R2: `s_ready` is 1 only when the outgoing request and the sender's synchronized acknowledge are both low. On the `s_clk` edge that accepts a word (`s_valid` and `s_ready` both 1), the request rises and `s_ready` goes low.
- R3: Every accepted word appears on `r_data` with `r_valid` exactly once, in acceptance order. This holds when the receiver clock is faster than, slower than, or close to the sender clock.
- R4: `r_valid` is a single-cycle pulse: it is never 1 on two consecutive `r_clk` edges.
- R5: The delivered word is the value of `s_data` at the accepting edge, whatever `s_data` does afterwards. The sender's internal data bus stays stable for as long as its request is high.
- R6: The acknowledge rises only in the `r_clk` cycle in which the word is captured and `r_valid` is 1. As a result, `s_ready` returns to 1 only after the previously accepted word has been presented on the receiving side.
- R7: `s_valid` asserted while `s_ready` is 0 is ignored, and no word is delivered for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| s_clk | input | 1 | Sending-domain clock |
| s_rst_n | input | 1 | Sending-domain asynchronous active-low reset |
| s_valid | input | 1 | Client offers a word |
| s_ready | output | 1 | Bridge idle and able to take a word |
| s_data | input | W | Word offered by the client |
| r_clk | input | 1 | Receiving-domain clock |
| r_rst_n | input | 1 | Receiving-domain asynchronous active-low reset |
| r_valid | output | 1 | One-cycle strobe: `r_data` holds a new word |
| r_data | output | W | Delivered word, held until the next strobe |

## Verification
The assertions assume that both resets are applied together at start-up and are not asserted on their own in the middle of a transfer. Under that assumption the two sides' handshake phases stay consistent. They also assume that the client changes `s_valid` and `s_data` only between `s_clk` edges. The stimulus asserts both resets from time zero and releases them once. It drives every input on falling edges. It lets the receiver clock period change only when the bridge is fully idle, and it runs three clock ratios: a fast receiver, a slow receiver and near-equal periods. Inside each ratio it adds random idle gaps and offers junk words while `s_ready` is low.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

  // Sender handshake phase. Bit 0 is set only in TX_HOLD so the request
  // line can be taken straight from a state flop (glitch-free crossing).
  typedef enum logic [1:0] {
    TX_IDLE = 2'b00,
    TX_HOLD = 2'b01,
    TX_RTZ  = 2'b10
  } tx_phase_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned DATA_W_DEF      = 32;

endpackage

// File: rtl/hsb_rstsync.sv
// Asynchronous assertion, synchronous release of an active-low reset.
module hsb_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/hsb_sync.sv
// Single-bit level synchronizer: the one and only entry point of a
// crossing control line into the local clock domain.
module hsb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/hsb_tx.sv
// Sending side: takes a word, holds it, runs the request half of the
// return-to-zero handshake against the synchronized acknowledge.
module hsb_tx
  import hsb_pkg::*;
#(
  parameter int unsigned W = DATA_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_data,
  input  logic         ack_sync,
  output logic         req_o,
  output logic [W-1:0] bus_o
);

  tx_phase_e    phase_q, phase_d;
  logic [W-1:0] hold_q, hold_d;
  logic         load_en;

  assign push_ready = (phase_q == TX_IDLE) && !ack_sync;
  assign load_en    = push_valid && push_ready;

  // next-state
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      TX_IDLE: if (load_en)   phase_d = TX_HOLD;
      TX_HOLD: if (ack_sync)  phase_d = TX_RTZ;
      TX_RTZ:  if (!ack_sync) phase_d = TX_IDLE;
      default:                phase_d = TX_IDLE;
    endcase
  end

  always_comb begin
    hold_d = hold_q;
    if (load_en) begin
      hold_d = push_data;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= TX_IDLE;
      hold_q  <= '0;
    end else begin
      phase_q <= phase_d;
      hold_q  <= hold_d;
    end
  end

  assign req_o = phase_q[0];
  assign bus_o = hold_q;

endmodule

// File: rtl/hsb_rx.sv
// Receiving side: captures the held word on the rising edge of the
// synchronized request and mirrors that request as the acknowledge.
module hsb_rx
  import hsb_pkg::*;
#(
  parameter int unsigned W = DATA_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_sync,
  input  logic [W-1:0] bus_i,
  output logic         ack_o,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  logic         ack_q, ack_d;
  logic         vld_q, vld_d;
  logic [W-1:0] cap_q, cap_d;
  logic         capture;

  // ack_q doubles as the previous request level: a new request is one
  // that is high while the acknowledge is still low.
  assign capture = req_sync && !ack_q;

  // next-state
  always_comb begin
    ack_d = req_sync;
    vld_d = capture;
    cap_d = cap_q;
    if (capture) begin
      cap_d = bus_i;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      vld_q <= 1'b0;
      cap_q <= '0;
    end else begin
      ack_q <= ack_d;
      vld_q <= vld_d;
      cap_q <= cap_d;
    end
  end

  assign ack_o     = ack_q;
  assign out_valid = vld_q;
  assign out_data  = cap_q;

endmodule

// File: rtl/hs_bridge.sv
module hs_bridge
  import hsb_pkg::*;
#(
  parameter int unsigned W           = DATA_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic         s_clk,
  input  logic         s_rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  input  logic         r_clk,
  input  logic         r_rst_n,
  output logic         r_valid,
  output logic [W-1:0] r_data
);

  logic         s_rst_sync_n;
  logic         r_rst_sync_n;
  logic         req_w;
  logic         ack_w;
  logic         req_in_r;
  logic         ack_in_s;
  logic [W-1:0] tx_data_w;

  hsb_rstsync #(.STAGES(SYNC_STAGES)) s_rst_i (
    .clk     (s_clk),
    .arst_n  (s_rst_n),
    .rst_n_o (s_rst_sync_n)
  );

  hsb_rstsync #(.STAGES(SYNC_STAGES)) r_rst_i (
    .clk     (r_clk),
    .arst_n  (r_rst_n),
    .rst_n_o (r_rst_sync_n)
  );

  hsb_tx #(.W(W)) tx_i (
    .clk        (s_clk),
    .rst_n      (s_rst_sync_n),
    .push_valid (s_valid),
    .push_ready (s_ready),
    .push_data  (s_data),
    .ack_sync   (ack_in_s),
    .req_o      (req_w),
    .bus_o      (tx_data_w)
  );

  // request enters the receiving domain here and nowhere else
  hsb_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
    .clk     (r_clk),
    .rst_n   (r_rst_sync_n),
    .d_async (req_w),
    .q_sync  (req_in_r)
  );

  hsb_rx #(.W(W)) rx_i (
    .clk       (r_clk),
    .rst_n     (r_rst_sync_n),
    .req_sync  (req_in_r),
    .bus_i     (tx_data_w),
    .ack_o     (ack_w),
    .out_valid (r_valid),
    .out_data  (r_data)
  );

  // acknowledge enters the sending domain here and nowhere else
  hsb_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
    .clk     (s_clk),
    .rst_n   (s_rst_sync_n),
    .d_async (ack_w),
    .q_sync  (ack_in_s)
  );

endmodule

// File: rtl/hs_bridge_chk.sv
module hs_bridge_chk #(
  parameter int unsigned W = 32
) (
  input logic         s_clk,
  input logic         s_rst_n,
  input logic         r_clk,
  input logic         r_rst_n,
  input logic         s_valid,
  input logic         s_ready,
  input logic         r_valid,
  input logic [W-1:0] r_data,
  input logic         req_w,
  input logic         ack_w,
  input logic [W-1:0] tx_data_w
);

  // R2
  ready_idle_chk: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    s_ready |-> !req_w);

  // R2
  accept_raises_req_chk: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    (s_valid && s_ready) |=> (req_w && !s_ready));

  // R4
  single_pulse_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    r_valid |=> !r_valid);

  // R5
  bus_hold_chk: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    (req_w && $past(req_w)) |-> $stable(tx_data_w));

  // R5
  data_match_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    r_valid |-> (r_data == tx_data_w));

  // R6
  ack_on_capture_chk: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    $rose(ack_w) |-> r_valid);

  // R1
  always_comb begin
    if (!r_rst_n) begin
      rx_reset_quiet_chk: assert (!r_valid);
    end
  end

endmodule

bind hs_bridge hs_bridge_chk #(.W(W)) chk_i (.*);

// File: tb/hs_bridge_tb_top.sv
`timescale 1ns/1ps
module hs_bridge_tb_top;

  localparam int unsigned W      = 32;
  localparam int unsigned NWORDS = 120;

  logic         s_clk = 1'b0;
  logic         r_clk = 1'b0;
  logic         s_rst_n, r_rst_n;
  logic         s_valid;
  logic         s_ready;
  logic [W-1:0] s_data;
  logic         r_valid;
  logic [W-1:0] r_data;

  realtime      r_half = 3.1;

  int unsigned  n_checks = 0;
  int unsigned  n_fails  = 0;
  int unsigned  n_pushed = 0;
  int unsigned  n_recv   = 0;
  int unsigned  n_junk   = 0;
  int unsigned  cyc      = 0;
  bit           done     = 1'b0;
  logic [W-1:0] exp_q[$];

  hs_bridge #(.W(W)) dut_i (
    .s_clk   (s_clk),
    .s_rst_n (s_rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (s_data),
    .r_clk   (r_clk),
    .r_rst_n (r_rst_n),
    .r_valid (r_valid),
    .r_data  (r_data)
  );

  always #4.0 s_clk = ~s_clk;
  always #(r_half) r_clk = ~r_clk;

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  // Driver: pushes one word, with random gaps and junk offers while busy.
  task automatic push_word(input logic [W-1:0] w);
    int gap = $urandom_range(0, 4);
    for (int i = 0; i < gap; i++) @(negedge s_clk);
    @(negedge s_clk);
    while (!s_ready) begin
      if ($urandom_range(0, 2) == 0) begin
        s_valid = 1'b1;              // R7: offer while not ready
        s_data  = $urandom();
        n_junk++;
      end else begin
        s_valid = 1'b0;
      end
      @(negedge s_clk);
    end
    s_valid = 1'b1;
    s_data  = w;
    @(posedge s_clk);
    exp_q.push_back(w);
    n_pushed++;
    @(negedge s_clk);
    s_valid = 1'b0;
    s_data  = ~w;                    // R5: data moves after acceptance
    check(!s_ready, "R2 ready low after accept", {31'd0, s_ready}, '0);
  endtask

  task automatic drain();
    @(negedge s_clk);
    while (exp_q.size() != 0 || !s_ready) @(negedge s_clk);
  endtask

  // Monitor / scoreboard on the receiving side.
  bit prev_rv = 1'b0;
  always @(negedge r_clk) begin
    if (r_rst_n) begin
      check(!(r_valid && prev_rv), "R4 valid longer than one cycle",
            {31'd0, r_valid}, '0);
      if (r_valid) begin
        n_recv++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R7 unexpected extra word", r_data, '0);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          check(r_data == e, "R3/R5 delivered word", r_data, e);
        end
      end
      prev_rv = r_valid;
    end
  end

  // R6: ready may only come back after the word has been presented.
  bit prev_rdy = 1'b1;
  always @(negedge s_clk) begin
    if (s_rst_n && n_pushed > 0 && s_ready && !prev_rdy) begin
      check(exp_q.size() == 0, "R6 ready back before delivery",
            exp_q.size(), '0);
    end
    prev_rdy = s_ready;
  end

  // Watchdog
  always @(posedge s_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    s_rst_n = 1'b0;
    r_rst_n = 1'b0;
    s_valid = 1'b0;
    s_data  = '0;
    repeat (5) @(negedge s_clk);
    check(!r_valid, "R1 r_valid low in reset", {31'd0, r_valid}, '0);
    s_rst_n = 1'b1;
    r_rst_n = 1'b1;
    repeat (6) @(negedge s_clk);
    check(s_ready, "R1 ready after reset", {31'd0, s_ready}, 1);
    check(!r_valid, "R1 no valid after reset", {31'd0, r_valid}, '0);

    // three clock ratios: fast, slow, near-equal receiver
    for (int ph = 0; ph < 3; ph++) begin
      r_half = (ph == 0) ? 3.1 : (ph == 1) ? 11.3 : 4.05;
      repeat (3) @(negedge s_clk);
      for (int k = 0; k < NWORDS; k++) begin
        push_word($urandom());
      end
      push_word('0);
      push_word('1);
      drain();
      repeat (40) @(negedge s_clk);
      check(exp_q.size() == 0, "R3 all words delivered", exp_q.size(), '0);
      check(n_recv == n_pushed, "R7 junk offers ignored (count)", n_recv, n_pushed);
    end
    check(n_junk > 0, "R7 junk offers were exercised", n_junk, 1);
    finish_run();
  end

endmodule